// File: doc/BRIEF.md
# EDO DRAM Cycle Decoder

This block is a clock-sampled model of the control section of a multiplexed-address DRAM with extended data-out paging. A controller under test, or a system model, drives the active-low strobes (row strobe, two column strobes for the low and high byte lanes, write enable and output enable), a shared 10-bit address bus and a split data bus. The block registers every strobe on each clock edge and detects edges on the sampled values. It captures the row and column halves of the word address and decides what kind of cycle each strobe sequence forms. It stores write data in a small array that is indexed by the low bits of the row and the column.

The block reports every classified cycle on a one-cycle strobe with a class code. For refresh cycles it also reports the row that was refreshed. A counter inside the block supplies the row for refreshes in which the column strobe comes before the row strobe. The output enable of the data bus follows the extended data-out rules: data are held after the column strobe rises, and output enable or write enable pulses can turn the outputs off. Each byte lane is driven or written only when its own column strobe selected it.

Top module: `edo_cycle_decoder`

## Requirements
- R1: The row is taken from `addr` in the sample where `ras_n` is first seen low, and the column from `addr` in the sample where the first column strobe is seen low. Storage is indexed by the low bits of both. While `ras_n` stays low, each new column strobe fall opens a page access to a new column in the same row.
- R2: `casl_n` selects lane 0 (`dq` bits 7:0) and `cash_n` selects lane 1 (bits 15:8). Writes change only the selected lanes. `dq_oe[i]` is set only for lanes selected in a read. `dq_out` carries the whole word read.
- R3: A column strobe fall with `we_n` high is a read and emits class 1. Every class strobe matches one expected cycle, and every expected cycle produces exactly one strobe.
- R4: A column strobe fall with `we_n` already low is an early write and emits class 2. It writes `dq_in` into the selected lanes, and `dq_oe` stays 0 whatever `oe_n` is.
- R5: If `we_n` falls while a read period is open and `oe_n` is high, the selected lanes are written from `dq_in`. This emits class 4 if the outputs drove data earlier in that period, and class 3 otherwise. If `oe_n` is low at that point, nothing is written, no class is emitted, and the read data stay driven.
- R6: After a read, with `ras_n` and `oe_n` held low, the outputs keep driving the same data after the column strobes rise, until the next column strobe fall.
- R7: An `oe_n` high pulse while the column strobe is low turns the outputs off and then back on with the same data. An `oe_n` rise while the column strobes are high turns the outputs off until the next read column fall. `dq_oe` is never set unless `oe_n` was low in the sample before.
- R8: A `we_n` fall while both column strobes are high turns the outputs off until a column strobe falls with `we_n` high.
- R9: Once `ras_n`, `casl_n` and `cash_n` are all sampled high, `dq_oe` is 0 from then on.
- R10: If a column strobe is low when `ras_n` falls, the cycle is a column-before-row refresh (class 6). `rfsh_row` shows an internal 10-bit counter, which starts at 0 after reset and advances by one after each such cycle. Output data held from a read carry through this hidden refresh.
- R11: A row opened and closed with no column strobe fall is a row-only refresh: class 5, with `rfsh_row` equal to the latched row.
- R12: If a lane falls in a mode (early write, or read/late) other than the mode already set for the open column period, `lane_err` pulses. That lane is neither written nor driven for the rest of the period. The next period, after both column strobes have been high, starts clean.
- R13: Each output reflects the inputs sampled at the previous clock edge. During reset, `dq_oe`, `cyc_stb` and `lane_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| casl_n | input | 1 | Column strobe for lane 0, active low |
| cash_n | input | 1 | Column strobe for lane 1, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 10 | Multiplexed row/column address |
| dq_in | input | 16 | Data bus input side |
| dq_out | output | 16 | Data bus output side (word read) |
| dq_oe | output | 2 | Per-lane output drive enable |
| cyc_stb | output | 1 | One-cycle pulse when a cycle is classified |
| cyc_class | output | 3 | Class code: 1 read, 2 early write, 3 late write, 4 read-modify-write, 5 row-only refresh, 6 column-before-row refresh |
| rfsh_row | output | 10 | Row of the last refresh |
| lane_err | output | 1 | Pulse on a lane mode conflict |

## Verification
The checker verifies on every cycle the properties that follow directly from the sampled strobes. The outputs stay off during early writes and row-only refreshes, and whenever row and column strobes were all high. Output drive implies that output enable was low in the sample before. Refresh-by-counter and lane conflicts occur only with the required column strobe levels. The bench scenarios alone cover stored data through page accesses and byte-lane merges, the hold of extended data-out, the off-and-on patterns of output enable and write enable pulses, and the late write versus read-modify-write distinction. They also show that a late write blocked by output enable leaves the cell unchanged, that the refresh counter steps, and that a conflicting lane is kept from writing.

// File: rtl/edo_pkg.sv
package edo_pkg;
  typedef enum logic [2:0] {
    CYC_NONE  = 3'd0,
    CYC_READ  = 3'd1,
    CYC_EARLY = 3'd2,
    CYC_LATE  = 3'd3,
    CYC_RMW   = 3'd4,
    CYC_RONLY = 3'd5,
    CYC_CBR   = 3'd6
  } cyc_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ROW  = 2'd1,
    ST_RFSH = 2'd2
  } st_e;
endpackage

// File: rtl/edo_strobe_edge.sv
module edo_strobe_edge (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ras_n,
  input  logic       casl_n,
  input  logic       cash_n,
  input  logic       we_n,
  input  logic       oe_n,
  output logic       ras_fall,
  output logic       ras_rise,
  output logic       cas_fall,
  output logic       cas_act,
  output logic [1:0] lane_low,
  output logic [1:0] lane_fall,
  output logic       we_fall,
  output logic       oe_rise
);
  logic       ras_q;
  logic [1:0] cas_q;
  logic       we_q;
  logic       oe_q;
  logic [1:0] cas_v;

  assign cas_v     = {cash_n, casl_n};
  assign lane_low  = ~cas_v;
  assign cas_act   = |lane_low;
  assign ras_fall  = ras_q & ~ras_n;
  assign ras_rise  = ~ras_q & ras_n;
  assign lane_fall = cas_q & ~cas_v;
  assign cas_fall  = (&cas_q) & cas_act;
  assign we_fall   = we_q & ~we_n;
  assign oe_rise   = ~oe_q & oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q <= 1'b1;
      cas_q <= 2'b11;
      we_q  <= 1'b1;
      oe_q  <= 1'b1;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_v;
      we_q  <= we_n;
      oe_q  <= oe_n;
    end
  end
endmodule

// File: rtl/edo_rfsh_ctr.sv
module edo_rfsh_ctr #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] count
);
  logic [W-1:0] count_d;

  always_comb begin
    count_d = count;
    if (step) count_d = count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_d;
  end
endmodule

// File: rtl/edo_store.sv
module edo_store #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  parameter int IDX_W  = 5
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        wr_lane,
  input  logic [IDX_W-1:0]        widx,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [IDX_W-1:0]        ridx,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_lane[g]) cells[widx] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = cells[ridx];
  end
endmodule

// File: rtl/edo_cycle_decoder.sv
module edo_cycle_decoder #(
  parameter int ADDR_W    = 10,
  parameter int LANE_W    = 8,
  parameter int ROW_IDX_W = 2,
  parameter int COL_IDX_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ras_n,
  input  logic                  casl_n,
  input  logic                  cash_n,
  input  logic                  we_n,
  input  logic                  oe_n,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [2*LANE_W-1:0]   dq_in,
  output logic [2*LANE_W-1:0]   dq_out,
  output logic [1:0]            dq_oe,
  output logic                  cyc_stb,
  output logic [2:0]            cyc_class,
  output logic [ADDR_W-1:0]     rfsh_row,
  output logic                  lane_err
);
  import edo_pkg::*;

  localparam int LANES  = 2;
  localparam int DATA_W = LANES * LANE_W;
  localparam int IDX_W  = ROW_IDX_W + COL_IDX_W;

  logic             ras_fall, ras_rise, cas_fall, cas_act, we_fall, oe_rise;
  logic [LANES-1:0] lane_low, lane_fall;

  edo_strobe_edge u_edge (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .casl_n(casl_n), .cash_n(cash_n),
    .we_n(we_n), .oe_n(oe_n), .ras_fall(ras_fall), .ras_rise(ras_rise),
    .cas_fall(cas_fall), .cas_act(cas_act), .lane_low(lane_low),
    .lane_fall(lane_fall), .we_fall(we_fall), .oe_rise(oe_rise)
  );

  logic              step;
  logic [ADDR_W-1:0] rc_cnt;

  edo_rfsh_ctr #(.W(ADDR_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .step(step), .count(rc_cnt)
  );

  logic [LANES-1:0]  wr_lane;
  logic [IDX_W-1:0]  widx, ridx;
  logic [DATA_W-1:0] rdata;

  // State registers and their next values
  st_e                  st_q, st_d;
  logic [ADDR_W-1:0]    row_q, row_d;
  logic [COL_IDX_W-1:0] col_q, col_d;
  logic                 seen_q, seen_d;
  logic                 early_q, early_d;
  logic [LANES-1:0]     on_q, on_d;
  logic [LANES-1:0]     blk_q, blk_d;
  logic                 live_q, live_d;
  logic                 rdseen_q, rdseen_d;
  logic [DATA_W-1:0]    dout_q, dout_d;
  cyc_e                 cls_q, cls_d;
  logic                 stb_q, stb_d;
  logic [ADDR_W-1:0]    rrow_q, rrow_d;
  logic                 err_q, err_d;
  logic [LANES-1:0]     oe_q, oe_d;
  logic [LANES-1:0]     late_lanes;

  assign ridx = {row_q[ROW_IDX_W-1:0], addr[COL_IDX_W-1:0]};

  edo_store #(.LANES(LANES), .LANE_W(LANE_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .wr_lane(wr_lane), .widx(widx), .wdata(dq_in),
    .ridx(ridx), .rdata(rdata)
  );

  always_comb begin
    st_d       = st_q;
    row_d      = row_q;
    col_d      = col_q;
    seen_d     = seen_q;
    early_d    = early_q;
    on_d       = on_q;
    blk_d      = blk_q;
    live_d     = live_q;
    rdseen_d   = rdseen_q;
    dout_d     = dout_q;
    cls_d      = CYC_NONE;
    stb_d      = 1'b0;
    rrow_d     = rrow_q;
    err_d      = 1'b0;
    step       = 1'b0;
    wr_lane    = '0;
    widx       = {row_q[ROW_IDX_W-1:0], col_q};
    late_lanes = '0;

    case (st_q)
      ST_IDLE: begin
        if (ras_fall) begin
          if (cas_act) begin
            // column strobe already low: refresh from the counter
            st_d   = ST_RFSH;
            stb_d  = 1'b1;
            cls_d  = CYC_CBR;
            rrow_d = rc_cnt;
            step   = 1'b1;
          end else begin
            st_d   = ST_ROW;
            row_d  = addr;
            seen_d = 1'b0;
          end
        end
      end

      ST_ROW: begin
        if (ras_rise) begin
          st_d = ST_IDLE;
          if (!seen_q) begin
            stb_d  = 1'b1;
            cls_d  = CYC_RONLY;
            rrow_d = row_q;
          end
        end else if (cas_fall) begin
          // start of a column period: mode is fixed here
          col_d    = addr[COL_IDX_W-1:0];
          seen_d   = 1'b1;
          early_d  = ~we_n;
          blk_d    = '0;
          rdseen_d = 1'b0;
          widx     = ridx;
          stb_d    = 1'b1;
          if (!we_n) begin
            cls_d   = CYC_EARLY;
            wr_lane = lane_fall;
            on_d    = '0;
            live_d  = 1'b0;
          end else begin
            cls_d   = CYC_READ;
            dout_d  = rdata;
            on_d    = lane_fall;
            live_d  = 1'b1;
          end
        end else if (cas_act) begin
          if (|oe_q) rdseen_d = 1'b1;
          for (int i = 0; i < LANES; i++) begin
            if (lane_fall[i]) begin
              if ((~we_n) != early_q) begin
                err_d    = 1'b1;
                blk_d[i] = 1'b1;
              end else if (early_q) begin
                wr_lane[i] = 1'b1;
              end else begin
                on_d[i] = 1'b1;
              end
            end
          end
          if (we_fall && !early_q && oe_n) begin
            late_lanes = lane_low & ~blk_q & ~lane_fall;
            if (|late_lanes) begin
              wr_lane = wr_lane | late_lanes;
              stb_d   = 1'b1;
              cls_d   = rdseen_q ? CYC_RMW : CYC_LATE;
              live_d  = 1'b0;
            end
          end
        end else begin
          // column strobes high with the row open
          if (we_fall || oe_rise) live_d = 1'b0;
        end
      end

      ST_RFSH: begin
        if (ras_rise) st_d = ST_IDLE;
      end

      default: st_d = ST_IDLE;
    endcase

    if (ras_n && !cas_act) begin
      live_d = 1'b0;
      on_d   = '0;
    end

    oe_d = on_d & {LANES{live_d & ~oe_n}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      row_q    <= '0;
      col_q    <= '0;
      seen_q   <= 1'b0;
      early_q  <= 1'b0;
      on_q     <= '0;
      blk_q    <= '0;
      live_q   <= 1'b0;
      rdseen_q <= 1'b0;
      dout_q   <= '0;
      cls_q    <= CYC_NONE;
      stb_q    <= 1'b0;
      rrow_q   <= '0;
      err_q    <= 1'b0;
      oe_q     <= '0;
    end else begin
      st_q     <= st_d;
      row_q    <= row_d;
      col_q    <= col_d;
      seen_q   <= seen_d;
      early_q  <= early_d;
      on_q     <= on_d;
      blk_q    <= blk_d;
      live_q   <= live_d;
      rdseen_q <= rdseen_d;
      dout_q   <= dout_d;
      cls_q    <= cls_d;
      stb_q    <= stb_d;
      rrow_q   <= rrow_d;
      err_q    <= err_d;
      oe_q     <= oe_d;
    end
  end

  assign dq_out    = dout_q;
  assign dq_oe     = oe_q;
  assign cyc_stb   = stb_q;
  assign cyc_class = cls_q;
  assign rfsh_row  = rrow_q;
  assign lane_err  = err_q;
endmodule

// File: rtl/edo_cycle_decoder_chk.sv
module edo_cycle_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ras_n,
  input logic       casl_n,
  input logic       cash_n,
  input logic       oe_n,
  input logic [1:0] dq_oe,
  input logic       cyc_stb,
  input logic [2:0] cyc_class,
  input logic       lane_err
);
  import edo_pkg::*;

  AST_EARLY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_stb && cyc_class == CYC_EARLY) |-> dq_oe == 2'b00); // R4

  AST_DRIVE_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (|dq_oe) |-> !$past(oe_n)); // R7

  AST_ALL_HIGH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ras_n && casl_n && cash_n) |-> dq_oe == 2'b00); // R9

  AST_CBR_CAS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_stb && cyc_class == CYC_CBR) |-> !$past(casl_n && cash_n)); // R10

  AST_RONLY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_stb && cyc_class == CYC_RONLY) |-> dq_oe == 2'b00); // R11

  AST_CONFLICT_BOTH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    lane_err |-> (!$past(casl_n) && !$past(cash_n))); // R12
endmodule

bind edo_cycle_decoder edo_cycle_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .casl_n(casl_n), .cash_n(cash_n),
  .oe_n(oe_n), .dq_oe(dq_oe), .cyc_stb(cyc_stb), .cyc_class(cyc_class),
  .lane_err(lane_err)
);

// File: tb/edo_cycle_decoder_test.sv
module edo_cycle_decoder_test;
  localparam int CLK_NS = 10;

  logic        clk, rst_n, ras_n, casl_n, cash_n, we_n, oe_n;
  logic [9:0]  addr;
  logic [15:0] dq_in, dq_out;
  logic [1:0]  dq_oe;
  logic        cyc_stb, lane_err;
  logic [2:0]  cyc_class;
  logic [9:0]  rfsh_row;

  int checks = 0;
  int errors = 0;
  logic [12:0] exp_q [$];

  edo_cycle_decoder uut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .casl_n(casl_n), .cash_n(cash_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe(dq_oe), .cyc_stb(cyc_stb), .cyc_class(cyc_class),
    .rfsh_row(rfsh_row), .lane_err(lane_err)
  );

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_ev(input logic [2:0] cls, input logic [9:0] row);
    exp_q.push_back({cls, row});
  endtask

  task automatic chk_oe(input string req, input logic [1:0] exp);
    checks++;
    if (dq_oe !== exp) begin
      errors++;
      $display("FAIL %s dq_oe=%b expected %b", req, dq_oe, exp);
    end
  endtask

  task automatic chk_dout(input string req, input logic [15:0] exp);
    checks++;
    if (dq_out !== exp) begin
      errors++;
      $display("FAIL %s dq_out=%h expected %h", req, dq_out, exp);
    end
  endtask

  task automatic chk_err(input string req, input logic exp);
    checks++;
    if (lane_err !== exp) begin
      errors++;
      $display("FAIL %s lane_err=%b expected %b", req, lane_err, exp);
    end
  endtask

  // Scoreboard monitor: every class strobe pops one expected cycle
  always @(negedge clk) begin
    if (rst_n && cyc_stb) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R3 unexpected class %0d expected none", cyc_class);
      end else begin
        logic [12:0] e;
        e = exp_q.pop_front();
        if (cyc_class !== e[12:10]) begin
          errors++;
          $display("FAIL R3 class=%0d expected %0d", cyc_class, e[12:10]);
        end else if (e[12:10] >= 3'd5 && rfsh_row !== e[9:0]) begin
          errors++;
          $display("FAIL R10/R11 rfsh_row=%h expected %h", rfsh_row, e[9:0]);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run=hung expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ras_n = 1'b1; casl_n = 1'b1; cash_n = 1'b1;
    we_n = 1'b1; oe_n = 1'b1; addr = '0; dq_in = '0;
    repeat (3) tick();
    chk_oe("R13 reset", 2'b00);
    checks++;
    if (cyc_stb !== 1'b0) begin
      errors++; $display("FAIL R13 cyc_stb=%b expected 0", cyc_stb);
    end
    chk_err("R13 reset", 1'b0);
    rst_n = 1'b1; tick();

    // Early writes, row 1 (R4, R2)
    addr = 10'd1; ras_n = 1'b0; tick();
    we_n = 1'b0; oe_n = 1'b0; tick();
    addr = 10'd2; dq_in = 16'hA5C3; casl_n = 0; cash_n = 0; expect_ev(3'd2, 0); tick();
    chk_oe("R4 early write with oe low", 2'b00);
    casl_n = 1; cash_n = 1; tick();
    addr = 10'd3; dq_in = 16'h2233; casl_n = 0; cash_n = 0; expect_ev(3'd2, 0); tick();
    casl_n = 1; cash_n = 1; tick();
    dq_in = 16'h7711; casl_n = 0; expect_ev(3'd2, 0); tick();
    casl_n = 1; tick();
    we_n = 1; ras_n = 1; tick();
    // row 2 col 2 with other data (R1)
    addr = 10'd2; ras_n = 0; tick();
    we_n = 0; tick();
    dq_in = 16'h0F0F; casl_n = 0; cash_n = 0; expect_ev(3'd2, 0); tick();
    casl_n = 1; cash_n = 1; tick();
    we_n = 1; ras_n = 1; tick();

    // Reads, row 1 (R1, R2, R3, R6, R7, R8, R9)
    addr = 10'd1; ras_n = 0; tick();
    addr = 10'd2; casl_n = 0; cash_n = 0; expect_ev(3'd1, 0); tick();
    chk_oe("R3 read drives", 2'b11);
    chk_dout("R1 row 1 col 2", 16'hA5C3);
    casl_n = 1; cash_n = 1; tick();
    chk_oe("R6 hold after cas rise", 2'b11);
    tick();
    chk_oe("R6 hold continues", 2'b11);
    chk_dout("R6 held data", 16'hA5C3);
    addr = 10'd3; cash_n = 0; expect_ev(3'd1, 0); tick();
    chk_oe("R2 upper lane only", 2'b10);
    chk_dout("R2 lane merge", 16'h2211);
    cash_n = 1; tick();
    oe_n = 1; tick();
    chk_oe("R7 oe pulse after cas high", 2'b00);
    oe_n = 0; tick();
    chk_oe("R7 stays off after oe pulse", 2'b00);
    addr = 10'd2; casl_n = 0; cash_n = 0; expect_ev(3'd1, 0); tick();
    chk_oe("R7 next cas reopens", 2'b11);
    oe_n = 1; tick();
    chk_oe("R7 oe high during cas", 2'b00);
    oe_n = 0; tick();
    chk_oe("R7 back on during cas", 2'b11);
    chk_dout("R7 same data", 16'hA5C3);
    casl_n = 1; cash_n = 1; tick();
    we_n = 0; tick();
    chk_oe("R8 we pulse off", 2'b00);
    we_n = 1; tick();
    chk_oe("R8 stays off", 2'b00);
    casl_n = 0; cash_n = 0; expect_ev(3'd1, 0); tick();
    chk_oe("R8 read cas reopens", 2'b11);
    casl_n = 1; cash_n = 1; tick();
    ras_n = 1; tick();
    chk_oe("R9 all high off", 2'b00);

    // Late write, read-modify-write, blocked late write (R5)
    addr = 10'd1; ras_n = 0; tick();
    oe_n = 1; addr = 10'd4; casl_n = 0; cash_n = 0; expect_ev(3'd1, 0); tick();
    chk_oe("R5 read with oe high", 2'b00);
    dq_in = 16'h1357; we_n = 0; expect_ev(3'd3, 0); tick();
    we_n = 1; casl_n = 1; cash_n = 1; tick();
    oe_n = 0; addr = 10'd5; casl_n = 0; cash_n = 0; expect_ev(3'd1, 0); tick();
    tick();
    oe_n = 1; tick();
    dq_in = 16'h2468; we_n = 0; expect_ev(3'd4, 0); tick();
    we_n = 1; casl_n = 1; cash_n = 1; tick();
    oe_n = 0; addr = 10'd4; casl_n = 0; cash_n = 0; expect_ev(3'd1, 0); tick();
    chk_dout("R5 late write stored", 16'h1357);
    dq_in = 16'hFFFF; we_n = 0; tick();
    chk_oe("R5 oe low blocks write, still driving", 2'b11);
    chk_dout("R5 read data kept", 16'h1357);
    we_n = 1; casl_n = 1; cash_n = 1; tick();
    addr = 10'd5; casl_n = 0; cash_n = 0; expect_ev(3'd1, 0); tick();
    chk_dout("R5 rmw stored", 16'h2468);
    casl_n = 1; cash_n = 1; tick();
    addr = 10'd4; casl_n = 0; cash_n = 0; expect_ev(3'd1, 0); tick();
    chk_dout("R5 blocked write had no effect", 16'h1357);
    casl_n = 1; cash_n = 1; tick();
    ras_n = 1; tick();

    // Lane mode conflict (R12)
    addr = 10'd1; ras_n = 0; tick();
    we_n = 0; tick();
    addr = 10'd6; dq_in = 16'h5500; casl_n = 0; cash_n = 0; expect_ev(3'd2, 0); tick();
    casl_n = 1; cash_n = 1; tick();
    dq_in = 16'h00AA; casl_n = 0; expect_ev(3'd2, 0); tick();
    we_n = 1; tick();
    cash_n = 0; tick();
    chk_err("R12 conflict flagged", 1'b1);
    chk_oe("R12 blocked lane not driven", 2'b00);
    we_n = 0; oe_n = 1; dq_in = 16'hCC00; tick();
    casl_n = 1; cash_n = 1; we_n = 1; oe_n = 0; tick();
    chk_err("R12 pulse ends", 1'b0);
    casl_n = 0; cash_n = 0; expect_ev(3'd1, 0); tick();
    chk_dout("R12 blocked lane kept old data", 16'h55AA);
    chk_err("R12 clean period", 1'b0);
    chk_oe("R12 both lanes read", 2'b11);
    casl_n = 1; cash_n = 1; ras_n = 1; tick();

    // Row-only refresh (R11)
    addr = 10'h2A5; ras_n = 0; tick();
    ras_n = 1; expect_ev(3'd5, 10'h2A5); tick();

    // Column-before-row refresh and counter (R10)
    casl_n = 0; cash_n = 0; tick();
    ras_n = 0; expect_ev(3'd6, 10'd0); tick();
    chk_oe("R10 refresh no drive", 2'b00);
    ras_n = 1; tick();
    casl_n = 1; cash_n = 1; tick();
    casl_n = 0; cash_n = 0; tick();
    ras_n = 0; expect_ev(3'd6, 10'd1); tick();
    ras_n = 1; tick();
    casl_n = 1; cash_n = 1; tick();
    // hidden refresh after a read
    addr = 10'd1; ras_n = 0; tick();
    addr = 10'd2; casl_n = 0; cash_n = 0; expect_ev(3'd1, 0); tick();
    ras_n = 1; tick();
    chk_oe("R10 data held over ras rise", 2'b11);
    ras_n = 0; expect_ev(3'd6, 10'd2); tick();
    chk_oe("R10 hidden refresh keeps drive", 2'b11);
    chk_dout("R10 hidden refresh data", 16'hA5C3);
    ras_n = 1; tick();
    casl_n = 1; cash_n = 1; tick();
    tick();
    chk_oe("R9 off after both rise", 2'b00);

    repeat (3) tick();
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R3 missing strobes=%0d expected 0", exp_q.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule